// File: doc/BRIEF.md
# I2C Transmit Abort Cause Register

This block holds the status word that explains why an I2C controller abandoned a transmit operation. The master and slave engines report each failure as a one-cycle event pulse, and the block turns each pulse into a sticky cause bit. Any set cause bit drives a single transmit-abort interrupt flag. Software reads the word to find the cause. It then clears the causes by reading either the abort-clear register or the clear-all-interrupts register; each read arrives here as a one-cycle strobe.

One cause is special: a START byte requested while restart is disabled. Its bit is tied to a live configuration condition (restart enable low, special high, general-call-or-start select high). A clear that hits it while that condition still holds removes it for one cycle only, and it then comes back. The upper bits of the same word hold a saturating count of transmit FIFO commands that were thrown away because of an abort. Only disabling the controller resets this count.

Top module: `i2c_abort_cause_reg`

## Requirements
- R1: A pulse on `evt_i[k]` (k in 0..16) sets cause bit k of `abrt_word_o` on the next clock edge, and the bit stays set until a clear. Bit order: 0 7-bit address nack, 1 first 10-bit address byte nack, 2 second 10-bit address byte nack, 3 data nack, 4 general call nack, 5 general call then read, 6 high-speed code acked, 7 START byte acked, 8 high-speed with restart off, 9 START byte with restart off, 10 10-bit read with restart off, 11 master mode disabled, 12 arbitration lost, 13 slave flush of stale TX data, 14 slave lost the bus, 15 slave read answered with a read command, 16 user abort.
- R2: A one-cycle strobe on `rd_clr_abrt_i` or on `rd_clr_all_i` clears every cause bit except bit 9 on the next edge. Bit 9 also clears when its condition is false.
- R3: The condition of bit 9 is `restart_en_i`=0, `special_i`=1 and `gc_or_start_i`=1. If a clear hits a set bit 9 while the condition holds, bit 9 reads 0 for exactly one cycle and reads 1 again on the following cycle, provided the condition still holds.
- R4: An event on bit 14 (slave lost the bus) also sets bit 12 (arbitration lost) on the same edge.
- R5: `tx_abrt_irq_o` is 1 exactly when at least one of cause bits 16:0 is set.
- R6: When an event and a clear strobe arrive in the same cycle, the event's bit is set after the edge.
- R7: Each cycle with `flush_i`=1 and `ctrl_en_i`=1 increments the flush count held in bits 31:23. Clear strobes leave the count unchanged.
- R8: The flush count reads 0 on the edge after any cycle with `ctrl_en_i`=0.
- R9: The flush count saturates at 511 and does not wrap.
- R10: After reset, `abrt_word_o` is 0 and `tx_abrt_irq_o` is 0.
- R11: Bits 22:17 of `abrt_word_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 17 | One-cycle abort event pulses, one per cause bit |
| rd_clr_abrt_i | input | 1 | Read strobe of the abort-clear register |
| rd_clr_all_i | input | 1 | Read strobe of the clear-all-interrupts register |
| restart_en_i | input | 1 | Configuration: restart enable |
| special_i | input | 1 | Configuration: special command select |
| gc_or_start_i | input | 1 | Configuration: general-call-or-START select |
| flush_i | input | 1 | One transmit FIFO command discarded this cycle |
| ctrl_en_i | input | 1 | Controller enable; low resets the flush count |
| abrt_word_o | output | 32 | Readable cause and flush-count word |
| tx_abrt_irq_o | output | 1 | Combined transmit-abort interrupt flag |

## Verification
The bench targets the level-qualified bit 9 with its condition held live across a clear. The bit must drop for exactly one cycle and then return. A design that cleared it for good, or never let it drop, fails at that point. A slave-lost-bus event must light arbitration-lost as well, and an event that coincides with a clear must survive; a design that gave the clear priority loses the new cause. The flush count is driven past 511 to catch wrap-around, is checked to survive a clear strobe, and is checked to reset when the controller is disabled.

// File: rtl/abrt_pkg.sv
package abrt_pkg;
  localparam int NUM_CAUSE     = 17;
  localparam int CNT_W         = 9;
  localparam int REG_W         = 32;
  localparam int RSV_W         = REG_W - NUM_CAUSE - CNT_W;
  localparam int B_SBYTE_NORST = 9;
  localparam int B_ARB_LOST    = 12;
  localparam int B_SLV_LOST    = 14;
endpackage

// File: rtl/abrt_rst_sync.sv
module abrt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/abrt_cause_bank.sv
module abrt_cause_bank #(
  parameter int N       = abrt_pkg::NUM_CAUSE,
  parameter int LVL_BIT = abrt_pkg::B_SBYTE_NORST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic         lvl_cond_i,
  output logic [N-1:0] cause_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g == LVL_BIT) begin : g_lvl
      // Level-qualified cause: a clear under a live condition re-arms it.
      logic q, q_nxt, pend, pend_nxt;

      always_comb begin
        q_nxt    = set_i[g] | (q & ~clr_i) | (pend & lvl_cond_i);
        pend_nxt = clr_i & q & lvl_cond_i & ~set_i[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q    <= 1'b0;
          pend <= 1'b0;
        end else begin
          q    <= q_nxt;
          pend <= pend_nxt;
        end
      end

      assign cause_o[g] = q;
    end else begin : g_std
      logic q, q_nxt, q_en;

      always_comb begin
        q_en  = set_i[g] | clr_i;
        q_nxt = set_i[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (q_en) q <= q_nxt;
      end

      assign cause_o[g] = q;
    end
  end
endmodule

// File: rtl/abrt_flush_counter.sv
module abrt_flush_counter #(
  parameter int W = abrt_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         flush_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = ~en_i | (flush_i & (cnt_q != CNT_MAX));
    cnt_nxt = en_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/i2c_abort_cause_reg.sv
module i2c_abort_cause_reg #(
  parameter int NUM_CAUSE = abrt_pkg::NUM_CAUSE,
  parameter int CNT_W     = abrt_pkg::CNT_W,
  parameter int REG_W     = abrt_pkg::REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] evt_i,
  input  logic                 rd_clr_abrt_i,
  input  logic                 rd_clr_all_i,
  input  logic                 restart_en_i,
  input  logic                 special_i,
  input  logic                 gc_or_start_i,
  input  logic                 flush_i,
  input  logic                 ctrl_en_i,
  output logic [REG_W-1:0]     abrt_word_o,
  output logic                 tx_abrt_irq_o
);
  localparam int RSV_W = REG_W - NUM_CAUSE - CNT_W;

  logic                 rst_q_n;
  logic                 clr_any;
  logic                 lvl_cond;
  logic [NUM_CAUSE-1:0] set_vec;
  logic [NUM_CAUSE-1:0] cause;
  logic [CNT_W-1:0]     flush_cnt;

  abrt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  always_comb begin
    clr_any  = rd_clr_abrt_i | rd_clr_all_i;
    lvl_cond = ~restart_en_i & special_i & gc_or_start_i;
    set_vec  = evt_i;
    // Slave bus loss always implies arbitration loss.
    set_vec[abrt_pkg::B_ARB_LOST] = evt_i[abrt_pkg::B_ARB_LOST] | evt_i[abrt_pkg::B_SLV_LOST];
  end

  abrt_cause_bank #(
    .N       (NUM_CAUSE),
    .LVL_BIT (abrt_pkg::B_SBYTE_NORST)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .set_i      (set_vec),
    .clr_i      (clr_any),
    .lvl_cond_i (lvl_cond),
    .cause_o    (cause)
  );

  abrt_flush_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .en_i    (ctrl_en_i),
    .flush_i (flush_i),
    .cnt_o   (flush_cnt)
  );

  assign abrt_word_o   = {flush_cnt, {RSV_W{1'b0}}, cause};
  assign tx_abrt_irq_o = |cause;
endmodule

// File: rtl/i2c_abort_cause_reg_chk.sv
module i2c_abort_cause_reg_chk #(
  parameter int NUM_CAUSE = abrt_pkg::NUM_CAUSE,
  parameter int CNT_W     = abrt_pkg::CNT_W,
  parameter int REG_W     = abrt_pkg::REG_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CAUSE-1:0] evt_i,
  input logic                 clr_i,
  input logic                 cond_i,
  input logic                 flush_i,
  input logic                 ctrl_en_i,
  input logic [REG_W-1:0]     word_i,
  input logic                 irq_i
);
  localparam int L9 = abrt_pkg::B_SBYTE_NORST;
  localparam int HI = REG_W - 1;
  localparam int LO = REG_W - CNT_W;
  localparam logic [NUM_CAUSE-1:0] MASK9 = ~(NUM_CAUSE'(1) << L9);
  localparam logic [CNT_W-1:0]     CMAX  = '1;

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((word_i[NUM_CAUSE-1:0] & $past(evt_i)) == $past(evt_i))); // R1
  AST_CLR_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> ((word_i[NUM_CAUSE-1:0] & MASK9) == '0)); // R2
  AST_LVL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && word_i[L9] && cond_i && !evt_i[L9]) |=> !word_i[L9]); // R3
  AST_LVL_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_i) && $past(word_i[L9]) && $past(cond_i) && !$past(evt_i[L9]) && cond_i)
      |=> word_i[L9]); // R3
  AST_SLV_ARB: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[abrt_pkg::B_SLV_LOST] |=> word_i[abrt_pkg::B_ARB_LOST]); // R4
  AST_IRQ_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> irq_i); // R5
  AST_CNT_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en_i |=> (word_i[HI:LO] == '0)); // R8
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en_i && word_i[HI:LO] == CMAX) |=> (word_i[HI:LO] == CMAX)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en_i && !flush_i) |=> $stable(word_i[HI:LO])); // R7
endmodule

bind i2c_abort_cause_reg i2c_abort_cause_reg_chk #(
  .NUM_CAUSE (NUM_CAUSE),
  .CNT_W     (CNT_W),
  .REG_W     (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .evt_i     (evt_i),
  .clr_i     (clr_any),
  .cond_i    (lvl_cond),
  .flush_i   (flush_i),
  .ctrl_en_i (ctrl_en_i),
  .word_i    (abrt_word_o),
  .irq_i     (tx_abrt_irq_o)
);

// File: tb/sim_i2c_abort_cause_reg.sv
module sim_i2c_abort_cause_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {event[16:0], clr_abrt, clr_all, expected cause[16:0]}
  localparam logic [35:0] VEC [NV] = '{
    {17'h00001, 1'b0, 1'b0, 17'h00001},  // R1
    {17'h00010, 1'b0, 1'b0, 17'h00011},  // R1
    {17'h04000, 1'b0, 1'b0, 17'h05011},  // R4
    {17'h00000, 1'b1, 1'b0, 17'h00000},  // R2
    {17'h10200, 1'b0, 1'b0, 17'h10200},  // R1
    {17'h00004, 1'b0, 1'b1, 17'h00004},  // R6 and R2 via clear-all
    {17'h000A0, 1'b0, 1'b0, 17'h000A4},  // R1
    {17'h00000, 1'b1, 1'b0, 17'h00000}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] evt = '0;
  logic        clr_a = 1'b0, clr_all = 1'b0, rst_en = 1'b1, spec = 1'b0, gcs = 1'b0;
  logic        flush = 1'b0, en = 1'b1;
  logic [31:0] word;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_abort_cause_reg u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_clr_abrt_i(clr_a), .rd_clr_all_i(clr_all),
    .restart_en_i(rst_en), .special_i(spec), .gc_or_start_i(gcs), .flush_i(flush),
    .ctrl_en_i(en), .abrt_word_o(word), .tx_abrt_irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; one rising edge passes; sample at the next falling edge.
  task automatic step(input logic [16:0] e, input logic ca, input logic cl, input logic fl);
    evt = e; clr_a = ca; clr_all = cl; flush = fl;
    @(negedge clk);
    evt = '0; clr_a = 1'b0; clr_all = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 word", word, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35:19], VEC[i][18], VEC[i][17], 1'b0);
      chk("R1/R2/R4/R6 table", word, {15'b0, VEC[i][16:0]});
      chk("R5 irq", {31'b0, irq}, {31'b0, |VEC[i][16:0]});
    end

    // R11: all causes set, reserved bits stay 0
    step(17'h1FFFF, 1'b0, 1'b0, 1'b0);
    chk("R11 reserved", word & 32'h007E_0000, 32'h0);
    step(17'h0, 1'b1, 1'b0, 1'b0);

    // R3: bit 9 with condition live
    rst_en = 1'b0; spec = 1'b1; gcs = 1'b1;
    step(17'h00200, 1'b0, 1'b0, 1'b0);
    chk("R3 set", word, 32'h0000_0200);
    step(17'h0, 1'b1, 1'b0, 1'b0);
    chk("R3 gap", word, 32'h0);
    step(17'h0, 1'b0, 1'b0, 1'b0);
    chk("R3 back", word, 32'h0000_0200);
    rst_en = 1'b1;
    step(17'h0, 1'b0, 1'b1, 1'b0);
    chk("R3 normal clear", word, 32'h0);
    step(17'h0, 1'b0, 1'b0, 1'b0);
    chk("R3 stays clear", word, 32'h0);

    // R7: count flushes, survive clear strobes
    for (int i = 0; i < 5; i++) step(17'h0, 1'b0, 1'b0, 1'b1);
    chk("R7 count", word, 32'd5 << 23);
    step(17'h0, 1'b1, 1'b1, 1'b0);
    chk("R7 clear ignored", word, 32'd5 << 23);

    // R8: disable resets count
    en = 1'b0;
    step(17'h0, 1'b0, 1'b0, 1'b1);
    chk("R8 disable", word, 32'h0);
    en = 1'b1;

    // R9: saturation
    for (int i = 0; i < 520; i++) step(17'h0, 1'b0, 1'b0, 1'b1);
    chk("R9 saturate", word, 32'd511 << 23);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule